// File: doc/BRIEF.md
# Barrier-Aware Memory Dependence Tracker

This block sits beside the issue logic of an out-of-order core and decides when each in-flight memory operation may leave for execution. Every accepted load, store, atomic or standalone barrier takes one slot. The slot records the operation's sequence number, whether its source registers are ready, and how many older producers it still waits on. Those producers are every outstanding barrier that applies to the operation or, when no barrier applies, a single producer named by an external dependence predictor.

Barriers are tracked as two slot-indexed sets. The load set holds full barriers, and loads and atomics wait on it. The store set holds both full and write barriers, and stores and atomics wait on it. A load or store flagged with acquire or release semantics joins these sets once its own lookup is finished. When a producer reports completion, its dependents' counts drop by one and its slot is freed. A squash drops every entry younger than a given sequence number. A separate clear input empties both barrier sets when a context is taken over.

Top module: `mdt_tracker`

## Requirements
- R1: `ins_ready` is low exactly when every slot is occupied or a squash is presented that cycle. An insert is accepted only when `ins_valid` and `ins_ready` are both high.
- R2: An insert with `ins_full_bar`=1 enters both barrier sets. An insert with only `ins_wr_bar`=1 enters the store set only, so later loads do not wait on it.
- R3: A load (`ins_kind`=0) or atomic (`ins_kind`=2) inserted while the load set is non-empty waits on every member of the load set.
- R4: A store (`ins_kind`=1) or atomic waits on the store set only when the load-set rule did not apply. The predicted producer is used only when neither barrier rule applied. A standalone barrier (`ins_kind`=3) waits on nothing.
- R5: A predicted producer of 0, or one whose sequence number is not held in any slot, adds no dependence.
- R6: An entry's count is set to the number of producers found at insert. Each completion of one of its producers lowers the count by one. The entry is eligible only when the count is zero and its registers are ready, either from `ins_regs_ok` or from a later `regs_valid` that matches its sequence number.
- R7: `rdy_valid` is a registered one-cycle pulse carrying the sequence number in `rdy_seq`. It fires at most once per entry and at most once per cycle, choosing the lowest eligible slot, and it appears on the clock edge after eligibility.
- R8: A load or store that carries barrier flags is looked up against the existing sets before it joins them, so it never waits on itself.
- R9: A completing entry (`cmp_valid`, `cmp_seq`) leaves both barrier sets and frees its slot.
- R10: `sq_valid` removes every entry whose sequence number is greater than `sq_seq`, including from the barrier sets. A removed entry never pulses `rdy_valid`.
- R11: `bar_clear` empties both barrier sets without removing any entry. A barrier inserted in the same cycle is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | New operation presented |
| ins_ready | output | 1 | A free slot exists and no squash is presented |
| ins_seq | input | SEQ_W | Sequence number of the new operation |
| ins_kind | input | 2 | 0 load, 1 store, 2 atomic, 3 standalone barrier |
| ins_full_bar | input | 1 | Operation orders both loads and stores |
| ins_wr_bar | input | 1 | Operation orders stores only |
| ins_pred_seq | input | SEQ_W | Predicted producer, 0 for none |
| ins_regs_ok | input | 1 | Source registers already ready at insert |
| regs_valid | input | 1 | Register readiness notice |
| regs_seq | input | SEQ_W | Entry whose registers became ready |
| cmp_valid | input | 1 | Completion notice |
| cmp_seq | input | SEQ_W | Entry that completed |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Entries with a greater sequence number are dropped |
| bar_clear | input | 1 | Empty both barrier sets |
| rdy_valid | output | 1 | Issue pulse |
| rdy_seq | output | SEQ_W | Sequence number being released |

## Verification
The bench goes after a store that waits on two store barriers at once and must stay blocked until both complete. A design with a single ready bit would release it after the first completion. It checks that a write barrier does not hold back a later load, and that a load that is itself an acquire does not deadlock on its own slot. It checks that a barrier precedes the predictor: a design that mixed the two would let an atomic behind a release go early. It also covers squash and clear of outstanding barriers, after which a following load must issue at once. A design that left stale bits behind would hang that load.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
  typedef enum logic [1:0] {
    K_LOAD   = 2'd0,
    K_STORE  = 2'd1,
    K_ATOMIC = 2'd2,
    K_BAR    = 2'd3
  } mem_kind_e;
endpackage

// File: rtl/mdt_seq_cam.sv
module mdt_seq_cam #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N-1:0]        vld,
  input  logic [N-1:0][W-1:0] tags,
  input  logic [W-1:0]        key,
  input  logic                en,
  output logic [N-1:0]        hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = en & vld[g] & (tags[g] == key);
  end
endmodule

// File: rtl/mdt_low_pick.sv
module mdt_low_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] oh,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    oh    = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        oh[i] = 1'b1;
        found = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/mdt_tracker.sv
module mdt_tracker
  import mdt_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [1:0]       ins_kind,
  input  logic             ins_full_bar,
  input  logic             ins_wr_bar,
  input  logic [SEQ_W-1:0] ins_pred_seq,
  input  logic             ins_regs_ok,
  input  logic             regs_valid,
  input  logic [SEQ_W-1:0] regs_seq,
  input  logic             cmp_valid,
  input  logic [SEQ_W-1:0] cmp_seq,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             bar_clear,
  output logic             rdy_valid,
  output logic [SEQ_W-1:0] rdy_seq
);
  localparam int CW = $clog2(NSLOT + 1);

  // state
  logic [NSLOT-1:0]             slot_vld, slot_regs, slot_done, ld_set, st_set;
  logic [NSLOT-1:0][SEQ_W-1:0]  seq_q;
  logic [NSLOT-1:0][CW-1:0]     cnt_q;
  logic [NSLOT-1:0][NSLOT-1:0]  dep_q;   // [producer][dependent]
  logic                         rdy_valid_q;
  logic [SEQ_W-1:0]             rdy_seq_q;

  // next state
  logic [NSLOT-1:0]             slot_vld_n, slot_regs_n, slot_done_n, ld_set_n, st_set_n;
  logic [NSLOT-1:0][CW-1:0]     cnt_n;
  logic [NSLOT-1:0][NSLOT-1:0]  dep_n;
  logic [SEQ_W-1:0]             pick_seq;

  // decode
  logic [NSLOT-1:0] cmp_hit, reg_hit, pred_hit, sq_kill, gone, live;
  logic [NSLOT-1:0] ld_eff, st_eff, deps, dec, elig;
  logic [NSLOT-1:0] free_oh, pick_oh;
  logic             free_any, pick_any, ins_fire, is_ld, is_st;
  logic [CW-1:0]    dep_cnt;
  mem_kind_e        kind;

  mdt_seq_cam #(.N(NSLOT), .W(SEQ_W)) u_cam_cmp (
    .vld(slot_vld), .tags(seq_q), .key(cmp_seq), .en(cmp_valid), .hit(cmp_hit));
  mdt_seq_cam #(.N(NSLOT), .W(SEQ_W)) u_cam_reg (
    .vld(slot_vld), .tags(seq_q), .key(regs_seq), .en(regs_valid), .hit(reg_hit));
  mdt_seq_cam #(.N(NSLOT), .W(SEQ_W)) u_cam_pred (
    .vld(slot_vld), .tags(seq_q), .key(ins_pred_seq), .en(ins_pred_seq != '0), .hit(pred_hit));

  for (genvar g = 0; g < NSLOT; g++) begin : g_sq
    assign sq_kill[g] = sq_valid & slot_vld[g] & (seq_q[g] > sq_seq);
  end

  mdt_low_pick #(.N(NSLOT)) u_free (.req(~slot_vld), .oh(free_oh), .any(free_any));
  mdt_low_pick #(.N(NSLOT)) u_pick (.req(elig),      .oh(pick_oh), .any(pick_any));

  assign gone      = cmp_hit | sq_kill;
  assign live      = slot_vld & ~gone;
  assign ld_eff    = ld_set & live;
  assign st_eff    = st_set & live;
  assign ins_ready = free_any & ~sq_valid;
  assign ins_fire  = ins_valid & ins_ready;
  assign kind      = mem_kind_e'(ins_kind);
  assign is_ld     = (kind == K_LOAD)  || (kind == K_ATOMIC);
  assign is_st     = (kind == K_STORE) || (kind == K_ATOMIC);

  // producer selection: load set, then store set, then predictor
  always_comb begin
    if (kind == K_BAR)             deps = '0;
    else if (is_ld && |ld_eff)     deps = ld_eff;
    else if (is_st && |st_eff)     deps = st_eff;
    else                           deps = pred_hit & live;
    dep_cnt = CW'($countones(deps));
  end

  // wake-up: one decrement per dependent of the completing producer
  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      dec[i] = 1'b0;
      for (int j = 0; j < NSLOT; j++) dec[i] = dec[i] | (cmp_hit[j] & dep_q[j][i]);
    end
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      elig[i] = slot_vld[i] & slot_regs[i] & ~slot_done[i] & (cnt_q[i] == '0) & ~gone[i];
  end

  always_comb begin
    pick_seq = '0;
    for (int i = 0; i < NSLOT; i++) if (pick_oh[i]) pick_seq = pick_seq | seq_q[i];
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      if (ins_fire && free_oh[i]) begin
        slot_vld_n[i]  = 1'b1;
        slot_regs_n[i] = ins_regs_ok;
        slot_done_n[i] = 1'b0;
        cnt_n[i]       = dep_cnt;
        ld_set_n[i]    = ins_full_bar;
        st_set_n[i]    = ins_full_bar | ins_wr_bar;
      end else begin
        slot_vld_n[i]  = slot_vld[i] & ~gone[i];
        slot_regs_n[i] = slot_regs[i] | reg_hit[i];
        slot_done_n[i] = slot_done[i] | pick_oh[i];
        cnt_n[i]       = dec[i] ? cnt_q[i] - CW'(1) : cnt_q[i];
        ld_set_n[i]    = ld_set[i] & ~gone[i] & ~bar_clear;
        st_set_n[i]    = st_set[i] & ~gone[i] & ~bar_clear;
      end
      for (int j = 0; j < NSLOT; j++) begin
        if (gone[j] || gone[i])            dep_n[j][i] = 1'b0;
        else if (ins_fire && free_oh[i])   dep_n[j][i] = deps[j];
        else                               dep_n[j][i] = dep_q[j][i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld    <= '0;
      slot_regs   <= '0;
      slot_done   <= '0;
      ld_set      <= '0;
      st_set      <= '0;
      cnt_q       <= '0;
      dep_q       <= '0;
      rdy_valid_q <= 1'b0;
      rdy_seq_q   <= '0;
    end else begin
      slot_vld    <= slot_vld_n;
      slot_regs   <= slot_regs_n;
      slot_done   <= slot_done_n;
      ld_set      <= ld_set_n;
      st_set      <= st_set_n;
      cnt_q       <= cnt_n;
      dep_q       <= dep_n;
      rdy_valid_q <= pick_any;
      if (pick_any) rdy_seq_q <= pick_seq;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_seq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      seq_q[g] <= '0;
      else if (ins_fire && free_oh[g]) seq_q[g] <= ins_seq;
    end
  end

  assign rdy_valid = rdy_valid_q;
  assign rdy_seq   = rdy_seq_q;
endmodule

// File: rtl/mdt_tracker_chk.sv
module mdt_tracker_chk #(
  parameter int NSLOT = 8,
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_ready,
  input logic             ins_fire,
  input logic             cmp_valid,
  input logic             sq_valid,
  input logic [SEQ_W-1:0] sq_seq,
  input logic             rdy_valid,
  input logic [SEQ_W-1:0] rdy_seq,
  input logic [NSLOT-1:0] slot_vld,
  input logic [NSLOT-1:0] ld_set,
  input logic [NSLOT-1:0] st_set,
  input logic [NSLOT-1:0] cmp_hit
);
  a_r1_stall_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_ready |-> (sq_valid || $countones(slot_vld) == NSLOT));

  a_r2_load_set_in_store_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_set & ~st_set) == '0);

  a_r9_sets_track_live_slots: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_set | st_set) & ~slot_vld) == '0);

  a_r9_completion_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && (cmp_hit != '0) && !sq_valid && !ins_fire)
      |=> $countones(slot_vld) == $past($countones(slot_vld)) - 1);

  a_r7_no_repeat_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_valid && $past(rdy_valid)) |-> rdy_seq != $past(rdy_seq));

  a_r10_no_pulse_for_squashed: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> !(rdy_valid && rdy_seq > $past(sq_seq)));
endmodule

bind mdt_tracker mdt_tracker_chk #(.NSLOT(NSLOT), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_ready(ins_ready), .ins_fire(ins_fire),
  .cmp_valid(cmp_valid), .sq_valid(sq_valid), .sq_seq(sq_seq),
  .rdy_valid(rdy_valid), .rdy_seq(rdy_seq), .slot_vld(slot_vld),
  .ld_set(ld_set), .st_set(st_set), .cmp_hit(cmp_hit));

// File: tb/test_mdt_tracker.sv
`timescale 1ns/1ps
module test_mdt_tracker;
  localparam int NSLOT = 8;
  localparam int SEQ_W = 16;
  localparam logic [2:0] OP_INS = 3'd0, OP_REG = 3'd1, OP_CMP = 3'd2,
                         OP_SQ  = 3'd3, OP_CLR = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] seq;
    logic [1:0]  kind;
    logic        full;
    logic        wr;
    logic [15:0] pred;
    logic        regs;
    logic        exp_v;
    logic [15:0] exp_seq;
    logic        exp_rdy;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{OP_INS, 16'd10, 2'd0, 1'b0, 1'b0, 16'd0,  1'b1, 1'b1, 16'd10, 1'b1}, // R5 pred zero
    '{OP_INS, 16'd11, 2'd1, 1'b0, 1'b0, 16'd10, 1'b1, 1'b0, 16'd0,  1'b1}, // R4 predictor dep
    '{OP_INS, 16'd12, 2'd0, 1'b0, 1'b0, 16'd99, 1'b1, 1'b1, 16'd12, 1'b1}, // R5 untracked
    '{OP_CMP, 16'd10, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b1, 16'd11, 1'b1}, // R6 wake
    '{OP_INS, 16'd20, 2'd3, 1'b1, 1'b0, 16'd0,  1'b1, 1'b1, 16'd20, 1'b1}, // R4 barrier no wait
    '{OP_INS, 16'd21, 2'd3, 1'b0, 1'b1, 16'd0,  1'b1, 1'b1, 16'd21, 1'b1}, // R2
    '{OP_INS, 16'd22, 2'd0, 1'b0, 1'b0, 16'd0,  1'b1, 1'b0, 16'd0,  1'b1}, // R3
    '{OP_INS, 16'd23, 2'd1, 1'b0, 1'b0, 16'd0,  1'b1, 1'b0, 16'd0,  1'b1}, // R6 two producers
    '{OP_CMP, 16'd20, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b1, 16'd22, 1'b1}, // R6 partial
    '{OP_CMP, 16'd21, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b1, 16'd23, 1'b1}, // R6 last
    '{OP_INS, 16'd30, 2'd0, 1'b1, 1'b0, 16'd0,  1'b1, 1'b1, 16'd30, 1'b1}, // R8 acquire
    '{OP_INS, 16'd31, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b0, 16'd0,  1'b1}, // R3
    '{OP_REG, 16'd31, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b0, 16'd0,  1'b1}, // R6 regs only
    '{OP_CMP, 16'd30, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b1, 16'd31, 1'b1}, // R9
    '{OP_INS, 16'd40, 2'd1, 1'b0, 1'b1, 16'd0,  1'b1, 1'b1, 16'd40, 1'b1}, // R8 release
    '{OP_INS, 16'd41, 2'd0, 1'b0, 1'b0, 16'd0,  1'b1, 1'b1, 16'd41, 1'b1}, // R2 load passes
    '{OP_INS, 16'd42, 2'd2, 1'b0, 1'b0, 16'd0,  1'b1, 1'b0, 16'd0,  1'b0}, // R4 atomic, R1 full
    '{OP_CMP, 16'd40, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b1, 16'd42, 1'b1}, // R9
    '{OP_INS, 16'd50, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b0, 16'd0,  1'b0}, // R1
    '{OP_SQ,  16'd45, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b0, 16'd0,  1'b1}, // R10
    '{OP_CMP, 16'd11, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b0, 16'd0,  1'b1}, // R9
    '{OP_CMP, 16'd12, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b0, 16'd0,  1'b1}, // R9
    '{OP_INS, 16'd60, 2'd3, 1'b1, 1'b0, 16'd0,  1'b1, 1'b1, 16'd60, 1'b1}, // R2
    '{OP_CLR, 16'd0,  2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b0, 16'd0,  1'b1}, // R11
    '{OP_INS, 16'd61, 2'd0, 1'b0, 1'b0, 16'd0,  1'b1, 1'b1, 16'd61, 1'b1}, // R11 no wait
    '{OP_INS, 16'd70, 2'd3, 1'b1, 1'b0, 16'd0,  1'b1, 1'b1, 16'd70, 1'b0}, // R1 full again
    '{OP_SQ,  16'd65, 2'd0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b0, 16'd0,  1'b1}, // R10 barrier squashed
    '{OP_INS, 16'd71, 2'd0, 1'b0, 1'b0, 16'd0,  1'b1, 1'b1, 16'd71, 1'b0}  // R10 no wait
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ins_valid, ins_ready, ins_full_bar, ins_wr_bar, ins_regs_ok;
  logic [SEQ_W-1:0] ins_seq, ins_pred_seq, regs_seq, cmp_seq, sq_seq, rdy_seq;
  logic [1:0]       ins_kind;
  logic             regs_valid, cmp_valid, sq_valid, bar_clear, rdy_valid;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mdt_tracker #(.NSLOT(NSLOT), .SEQ_W(SEQ_W)) i_mdt_tracker (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_seq(ins_seq), .ins_kind(ins_kind), .ins_full_bar(ins_full_bar),
    .ins_wr_bar(ins_wr_bar), .ins_pred_seq(ins_pred_seq), .ins_regs_ok(ins_regs_ok),
    .regs_valid(regs_valid), .regs_seq(regs_seq), .cmp_valid(cmp_valid),
    .cmp_seq(cmp_seq), .sq_valid(sq_valid), .sq_seq(sq_seq), .bar_clear(bar_clear),
    .rdy_valid(rdy_valid), .rdy_seq(rdy_seq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 0; ins_seq = '0; ins_kind = '0; ins_full_bar = 0; ins_wr_bar = 0;
    ins_pred_seq = '0; ins_regs_ok = 0; regs_valid = 0; regs_seq = '0;
    cmp_valid = 0; cmp_seq = '0; sq_valid = 0; sq_seq = '0; bar_clear = 0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    case (v.op)
      OP_INS: begin
        ins_valid = 1; ins_seq = v.seq; ins_kind = v.kind; ins_full_bar = v.full;
        ins_wr_bar = v.wr; ins_pred_seq = v.pred; ins_regs_ok = v.regs;
      end
      OP_REG: begin regs_valid = 1; regs_seq = v.seq; end
      OP_CMP: begin cmp_valid = 1; cmp_seq = v.seq; end
      OP_SQ:  begin sq_valid = 1; sq_seq = v.seq; end
      default: bar_clear = 1;
    endcase
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R7 reset rdy_valid", rdy_valid, 0);
    check("R1 reset ins_ready", ins_ready, 1);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      apply(TBL[k]);
      check($sformatf("R6/R7 row %0d rdy_valid", k), rdy_valid, TBL[k].exp_v);
      if (TBL[k].exp_v)
        check($sformatf("R7 row %0d rdy_seq", k), rdy_seq, TBL[k].exp_seq);
      check($sformatf("R1 row %0d ins_ready", k), ins_ready, TBL[k].exp_rdy);
    end
    // R7: the pulse lasts a single cycle
    @(negedge clk);
    check("R7 pulse ends", rdy_valid, 0);
    // R6: a register notice for a removed entry has no effect
    begin
      vec_t v;
      v = '{OP_REG, 16'd50, 2'd0, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 16'd0, 1'b0};
      apply(v);
      check("R10 squashed entry stays silent", rdy_valid, 0);
      // R9: freeing one slot lets an insert through again
      v = '{OP_CMP, 16'd22, 2'd0, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 16'd0, 1'b0};
      apply(v);
      check("R9 slot freed", ins_ready, 1);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule